// File: doc/BRIEF.md
# Thread-Tagged Store Buffer with Forwarding

This block is a single store buffer that two hardware thread contexts of one core share. Stores from either thread are written into it in arrival order. Each stored entry remembers which thread issued it and whether that store has become non-speculative. Committed stores leave from the oldest end toward a cache write port under a valid/ready handshake, one per cycle at most. Stores therefore reach memory in the order they were issued.

A load presents its thread number and address. In the same cycle the buffer reports whether one of that thread's own buffered stores covers the address, and if so it returns the data of the youngest such store. Stores written by the other thread are invisible to the load, even when the address matches. When the load misses, it has to take its value from the cache, and that value may be older than the other thread's pending store. This isolation keeps each thread's view of memory the same as it would be with a private buffer per thread.

Stores may be speculative. A per-thread commit pulse makes that thread's oldest speculative entry permanent. A per-thread squash discards every still-speculative entry of that thread. The survivors are packed toward the oldest end and keep their relative age.

Top module: `tagged_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `drain_valid` is 0, `st_ready` is 1 and `ld_hit` is 0.
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly when 8 entries are held, and a store offered while `st_ready` is 0 is dropped.
- R3: `ld_hit` is 1 when at least one buffered entry has thread id equal to `ld_tid` and address equal to `ld_addr`. `ld_data` is then the data of the most recently accepted such entry.
- R4: Entries whose thread id differs from `ld_tid` never produce a hit. On a miss `ld_data` is 0.
- R5: A pulse on `commit_pulse[t]` marks the oldest uncommitted entry of thread t as committed. It leaves other entries unchanged, does nothing when thread t has no uncommitted entry, and never applies to a store accepted in the same cycle.
- R6: `drain_valid` is 1 exactly when the oldest entry exists and is committed. `drain_addr` and `drain_data` carry that entry, and it is removed on a cycle with `drain_valid` and `drain_ready`. An uncommitted oldest entry blocks draining, so entries drain strictly in acceptance order.
- R7: A pulse on `squash_req[t]` removes every entry of thread t that is still uncommitted, after any same-cycle commit has been applied. All other entries survive in their original relative order.
- R8: The lookup is combinational, and it searches committed and uncommitted entries alike.
- R9: A store accepted in a cycle is not visible to the lookup until the following cycle, and a same-cycle squash does not remove it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can accept a store |
| st_tid | input | 1 | Thread of the offered store |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| ld_tid | input | 1 | Thread of the load lookup |
| ld_addr | input | 32 | Load address |
| ld_hit | output | 1 | A same-thread buffered store matches |
| ld_data | output | 32 | Forwarded data, 0 on miss |
| commit_pulse | input | 2 | Per-thread commit, bit t for thread t |
| squash_req | input | 2 | Per-thread squash, bit t for thread t |
| drain_valid | output | 1 | Oldest entry is committed and offered to the cache |
| drain_ready | input | 1 | Cache accepts the offered entry |
| drain_addr | output | 32 | Address of the offered entry |
| drain_data | output | 32 | Data of the offered entry |

## Verification
A wrong tag, a wrong commit flag or a wrong age position inside the buffer cannot hide for long. It shows up at the lookup port in the same cycle a load probes that address. It also shows up on the drain port as soon as the damaged entry becomes the oldest one. A squash that removes the wrong entries, or breaks their order, changes the hit/miss answer on the next lookup. It also changes the address sequence seen on the drain side. For this reason the bench compares the ready, lookup and drain outputs against a behavioural queue model on every cycle. It runs directed sequences for each corner case and then a long mixed random phase over a small set of addresses, so that many address collisions occur.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int unsigned TID_W   = 1;
    localparam int unsigned NUM_THR = 1 << TID_W;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned DEPTH   = 8;

    typedef struct packed {
        logic              live;
        logic              done;
        logic [TID_W-1:0]  tid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/stb_fwd_search.sv
module stb_fwd_search
    import stb_pkg::*;
#(
    parameter int unsigned N = DEPTH
) (
    input  slot_t [N-1:0]      slots,
    input  logic [TID_W-1:0]   ld_tid,
    input  logic [ADDR_W-1:0]  ld_addr,
    output logic               hit,
    output logic [DATA_W-1:0]  data
);
    // Index 0 is oldest; a later match overrides, so the youngest wins.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (slots[i].live && slots[i].tid == ld_tid && slots[i].addr == ld_addr) begin
                hit  = 1'b1;
                data = slots[i].data;
            end
        end
    end
endmodule

// File: rtl/stb_commit_mark.sv
module stb_commit_mark
    import stb_pkg::*;
#(
    parameter int unsigned N = DEPTH
) (
    input  slot_t [N-1:0]        slots,
    input  logic [NUM_THR-1:0]   commit,
    output slot_t [N-1:0]        marked
);
    always_comb begin
        logic seen;
        marked = slots;
        for (int t = 0; t < int'(NUM_THR); t++) begin
            seen = 1'b0;
            for (int i = 0; i < int'(N); i++) begin
                if (!seen && commit[t] && slots[i].live && !slots[i].done
                    && slots[i].tid == TID_W'(t)) begin
                    marked[i].done = 1'b1;
                    seen           = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stb_compact.sv
module stb_compact
    import stb_pkg::*;
#(
    parameter int unsigned N = DEPTH,
    localparam int unsigned IDX_W = $clog2(N),
    localparam int unsigned CNT_W = $clog2(N + 1)
) (
    input  slot_t [N-1:0]    slots,
    input  logic  [N-1:0]    keep,
    output slot_t [N-1:0]    packed_slots,
    output logic [CNT_W-1:0] kept
);
    // Survivors move toward index 0 in their original order.
    always_comb begin
        int n;
        packed_slots = '0;
        n = 0;
        for (int i = 0; i < int'(N); i++) begin
            if (keep[i]) begin
                packed_slots[IDX_W'(n)] = slots[i];
                n = n + 1;
            end
        end
        kept = CNT_W'(n);
    end
endmodule

// File: rtl/tagged_store_buffer.sv
module tagged_store_buffer
    import stb_pkg::*;
#(
    parameter int unsigned N = DEPTH,
    localparam int unsigned IDX_W = $clog2(N),
    localparam int unsigned CNT_W = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                st_valid,
    output logic                st_ready,
    input  logic [TID_W-1:0]    st_tid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [DATA_W-1:0]   st_data,
    input  logic [TID_W-1:0]    ld_tid,
    input  logic [ADDR_W-1:0]   ld_addr,
    output logic                ld_hit,
    output logic [DATA_W-1:0]   ld_data,
    input  logic [NUM_THR-1:0]  commit_pulse,
    input  logic [NUM_THR-1:0]  squash_req,
    output logic                drain_valid,
    input  logic                drain_ready,
    output logic [ADDR_W-1:0]   drain_addr,
    output logic [DATA_W-1:0]   drain_data
);
    slot_t [N-1:0]    q_r, q_marked, q_packed, q_next;
    logic [CNT_W-1:0] cnt_r, kept;
    logic [N-1:0]     keep;
    logic             st_fire, drain_fire;

    assign st_ready    = cnt_r < CNT_W'(N);
    assign st_fire     = st_valid && st_ready;
    assign drain_valid = q_r[0].live && q_r[0].done;
    assign drain_addr  = q_r[0].addr;
    assign drain_data  = q_r[0].data;
    assign drain_fire  = drain_valid && drain_ready;

    stb_fwd_search #(.N(N)) u_search (
        .slots(q_r), .ld_tid(ld_tid), .ld_addr(ld_addr), .hit(ld_hit), .data(ld_data)
    );

    stb_commit_mark #(.N(N)) u_mark (
        .slots(q_r), .commit(commit_pulse), .marked(q_marked)
    );

    for (genvar i = 0; i < int'(N); i++) begin : g_keep
        if (i == 0) begin : g_head
            assign keep[i] = q_marked[i].live && !drain_fire
                             && !(squash_req[q_marked[i].tid] && !q_marked[i].done);
        end else begin : g_body
            assign keep[i] = q_marked[i].live
                             && !(squash_req[q_marked[i].tid] && !q_marked[i].done);
        end
    end

    stb_compact #(.N(N)) u_compact (
        .slots(q_marked), .keep(keep), .packed_slots(q_packed), .kept(kept)
    );

    always_comb begin
        q_next = q_packed;
        if (st_fire) begin
            q_next[kept[IDX_W-1:0]] = '{live: 1'b1, done: 1'b0, tid: st_tid,
                                        addr: st_addr, data: st_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            cnt_r <= '0;
        end else begin
            q_r   <= q_next;
            cnt_r <= kept + CNT_W'(st_fire);
        end
    end

    // R2: occupancy never exceeds capacity
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt_r <= CNT_W'(N));

    // R2: a refused store does not grow the buffer
    p_stall_no_grow_r2: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> cnt_r <= $past(cnt_r));

    // R6: an offered drain holds steady until accepted
    p_drain_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_ready) |=> drain_valid && $stable(drain_addr) && $stable(drain_data));

    // R7: a squash cycle without an accepted store never grows the buffer
    p_squash_no_grow_r7: assert property (@(posedge clk) disable iff (rst)
        ((|squash_req) && !st_fire) |=> cnt_r <= $past(cnt_r));

    // R3: a hit needs a non-empty buffer
    p_hit_needs_entry_r3: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> cnt_r != '0);
endmodule

// File: tb/tagged_store_buffer_bench.sv
module tagged_store_buffer_bench;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_ready, st_tid;
    logic [31:0] st_addr, st_data;
    logic        ld_tid, ld_hit;
    logic [31:0] ld_addr, ld_data;
    logic [1:0]  commit_pulse, squash_req;
    logic        drain_valid, drain_ready;
    logic [31:0] drain_addr, drain_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          tid;
        bit          done;
        logic [31:0] addr;
        logic [31:0] data;
    } m_t;
    m_t mq[$];

    always #(CLK_NS/2) clk = ~clk;

    tagged_store_buffer u_tagged_store_buffer (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_tid(st_tid),
        .st_addr(st_addr), .st_data(st_data),
        .ld_tid(ld_tid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .commit_pulse(commit_pulse), .squash_req(squash_req),
        .drain_valid(drain_valid), .drain_ready(drain_ready),
        .drain_addr(drain_addr), .drain_data(drain_data)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(bit sv, bit stid, logic [31:0] sa, logic [31:0] sd,
                         logic [1:0] cm, logic [1:0] sq, bit dr,
                         bit lt, logic [31:0] la);
        st_valid = sv; st_tid = stid; st_addr = sa; st_data = sd;
        commit_pulse = cm; squash_req = sq; drain_ready = dr;
        ld_tid = lt; ld_addr = la;
    endtask

    // Compare outputs against the model, then advance both by one clock.
    task automatic step(string tag);
        bit          e_ready, e_dv, e_hit, do_drain, accept, found;
        logic [31:0] e_data;
        m_t          keepq[$];
        #1;
        e_ready = mq.size() < 8;
        e_dv    = mq.size() > 0 && mq[0].done;
        e_hit   = 1'b0;
        e_data  = '0;
        foreach (mq[i]) if (mq[i].tid == ld_tid && mq[i].addr == ld_addr) begin
            e_hit = 1'b1; e_data = mq[i].data;
        end
        chk(st_ready === e_ready, {"R2 ", tag}, "st_ready", 32'(st_ready), 32'(e_ready));
        chk(drain_valid === e_dv, {"R6 ", tag}, "drain_valid", 32'(drain_valid), 32'(e_dv));
        if (e_dv) begin
            chk(drain_addr === mq[0].addr, {"R6 ", tag}, "drain_addr", drain_addr, mq[0].addr);
            chk(drain_data === mq[0].data, {"R6 ", tag}, "drain_data", drain_data, mq[0].data);
        end
        chk(ld_hit === e_hit, {"R3 R4 R8 ", tag}, "ld_hit", 32'(ld_hit), 32'(e_hit));
        chk(ld_data === e_data, {"R3 R4 ", tag}, "ld_data", ld_data, e_data);
        @(posedge clk);
        do_drain = drain_ready && e_dv;
        accept   = st_valid && e_ready;
        for (int t = 0; t < 2; t++) begin
            if (commit_pulse[t]) begin
                found = 1'b0;
                foreach (mq[i]) if (!found && mq[i].tid == t[0] && !mq[i].done) begin
                    mq[i].done = 1'b1; found = 1'b1;
                end
            end
        end
        if (do_drain) void'(mq.pop_front());
        keepq = {};
        foreach (mq[i]) if (!(squash_req[mq[i].tid] && !mq[i].done)) keepq.push_back(mq[i]);
        mq = keepq;
        if (accept) mq.push_back('{tid: st_tid, done: 1'b0, addr: st_addr, data: st_data});
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 32'h100);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(drain_valid === 1'b0, "R1", "drain_valid", 32'(drain_valid), 0);
        chk(st_ready === 1'b1, "R1", "st_ready", 32'(st_ready), 1);
        chk(ld_hit === 1'b0, "R1", "ld_hit", 32'(ld_hit), 0);

        // R3 R9: youngest same-thread store forwards; same-cycle store invisible
        drive(1, 0, 32'h100, 32'hA1, 0, 0, 0, 0, 32'h100); step("R9");
        drive(1, 0, 32'h104, 32'hA2, 0, 0, 0, 0, 32'h100); step("R3");
        drive(1, 0, 32'h100, 32'hA3, 0, 0, 0, 0, 32'h100); step("R9");
        drive(1, 1, 32'h100, 32'hB1, 0, 0, 0, 0, 32'h100); step("R3");
        // R4: other thread's younger store to same address is invisible
        drive(1, 0, 32'h100, 32'hA4, 0, 0, 0, 1, 32'h100); step("R4");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h104); step("R4");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h100); step("R4");
        // R2: fill to capacity and hold a store against a full buffer
        for (int k = 0; k < 5; k++) begin
            drive(1, k[0], 32'h200 + 32'(k*4), 32'hC0 + 32'(k), 0, 0, 0, 0, 32'h100);
            step("R2");
        end
        drive(1, 1, 32'h300, 32'hDEAD, 0, 0, 0, 1, 32'h300); step("R2");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h300); step("R2");
        // R6: uncommitted head blocks drain even with ready high
        drive(0, 0, 0, 0, 0, 0, 1, 0, 32'h100); step("R6");
        // R5: commit thread 1 only marks thread 1; head (thread 0) still blocks
        drive(0, 0, 0, 0, 2'b10, 0, 1, 0, 32'h100); step("R5");
        drive(0, 0, 0, 0, 2'b01, 0, 0, 0, 32'h100); step("R5");
        drive(0, 0, 0, 0, 2'b01, 0, 1, 0, 32'h100); step("R6");
        drive(0, 0, 0, 0, 2'b00, 0, 1, 0, 32'h100); step("R6");
        drive(0, 0, 0, 0, 2'b00, 0, 1, 1, 32'h100); step("R6");
        // R7: squash thread 1 with a same-cycle commit of thread 1 and a store (R9)
        drive(1, 1, 32'h104, 32'hE1, 2'b10, 2'b10, 0, 1, 32'h204); step("R7");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h104); step("R9");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h20C); step("R7");
        drive(0, 0, 0, 0, 0, 2'b01, 0, 0, 32'h100); step("R7");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 32'h204); step("R7");
        // R5: commit with nothing pending has no effect
        drive(0, 0, 0, 0, 2'b11, 0, 0, 0, 32'h100); step("R5");
        drive(0, 0, 0, 0, 2'b11, 0, 1, 1, 32'h104); step("R5");
        for (int k = 0; k < 10; k++) begin
            drive(0, 0, 0, 0, 0, 0, 1, 1, 32'h104); step("R6");
        end

        // Mixed random phase over a small address set
        for (int k = 0; k < 3000; k++) begin
            drive($urandom_range(0, 3) != 0, 1'($urandom), 32'h40 + 32'($urandom_range(0, 3) * 4),
                  $urandom, 2'($urandom_range(0, 3) == 0 ? $urandom : 0),
                  2'($urandom_range(0, 15) == 0 ? $urandom : 0),
                  $urandom_range(0, 2) != 0, 1'($urandom),
                  32'h40 + 32'($urandom_range(0, 3) * 4));
            step("MIX R5 R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule